// File: doc/BRIEF.md
# Supply Window Fault Comparator

This block watches one supply rail through a stream of 8-bit digitized samples and raises a single raw fault flag when the rail leaves its allowed band. It holds two independent limit trackers: one for the low side (undervoltage) and one for the high side (overvoltage). Each tracker has its own 8-bit threshold code and its own 5-bit hysteresis code. A tracker trips as soon as a valid sample crosses its threshold. Once tripped, it releases only after the sample has moved back past the threshold by the hysteresis amount. This keeps a rail sitting close to a limit from making the flag chatter.

A 2-bit selector decides what the flag reports: the high-side state, the low-side state, or the OR of both (an out-of-band fault). A polarity input sets up the block for a negative rail. In that mode the sample is read as a two's-complement code and its magnitude is compared against the thresholds. The flag is raw: any time-domain deglitching belongs downstream.

Top module: `supply_window_fault`

## Requirements
- R1: On a clock edge with `smp_valid` high, a clear low-side state becomes set when the compared magnitude is strictly less than `uv_level`.
- R2: A set low-side state clears on a valid sample only when the magnitude is strictly greater than `uv_level + uv_hyst`. At or below that level it stays set.
- R3: On a valid sample, a clear high-side state becomes set when the magnitude is strictly greater than `ov_level`.
- R4: A set high-side state clears on a valid sample only when the magnitude is strictly less than `ov_level - ov_hyst`. At or above that level it stays set.
- R5: Each hysteresis code is 5 bits wide, so it spans 0 to 31 codes, and the full value 31 is honoured.
- R6: With `smp_valid` low, neither state changes, whatever the sample value.
- R7: `fault_sel` encoding: 2'b00 reports the high-side state only, 2'b01 the low-side state only, and 2'b10 and 2'b11 both report the OR of the two states. `fault` follows the states and the selector combinationally, with no added register.
- R8: With `neg_mode` high, the compared magnitude is the absolute value of `smp_code` taken as two's complement (code 8'h80 gives 128). With `neg_mode` low, the magnitude is the code as unsigned.
- R9: A synchronous active-low reset clears both states, so `fault` is 0 after a reset edge.
- R10: The release levels saturate: `uv_level + uv_hyst` is limited to 255 and `ov_level - ov_hyst` to 0. A low-side fault with a release level of 255, or a high-side fault with a release level of 0, never clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; states update only when high |
| smp_code | input | 8 | Digitized supply sample |
| neg_mode | input | 1 | 1 = negative rail, compare the two's-complement magnitude |
| uv_level | input | 8 | Low-side trip threshold code |
| ov_level | input | 8 | High-side trip threshold code |
| uv_hyst | input | 5 | Low-side release hysteresis code |
| ov_hyst | input | 5 | High-side release hysteresis code |
| fault_sel | input | 2 | Report selector (see R7) |
| fault | output | 1 | Raw fault flag |

## Verification
Each tracker state is one register, so a wrong state appears at `fault` one cycle after the valid sample that caused it. It can be masked only when `fault_sel` hides that side. For this reason the bench flips the selector while a single side is tripped, to bring each state out on its own. Errors in the release level, in hysteresis width or in saturation stay hidden until a sample lands exactly on the boundary. The stimulus therefore walks samples one code at a time across each release point, and up to the saturated limits.

// File: rtl/sfd_pkg.sv
// Package: shared encodings for the supply window fault comparator.
// Assumes an 8-bit default sample width; widths are parameters in the modules.
package sfd_pkg;

    // Report selector codes; the reserved code behaves as the window code.
    typedef enum logic [1:0] {
        SEL_HIGH   = 2'b00,
        SEL_LOW    = 2'b01,
        SEL_WINDOW = 2'b10,
        SEL_RSVD   = 2'b11
    } fault_sel_e;

endpackage

// File: rtl/sfd_magnitude.sv
// Module: sfd_magnitude
// Turns the raw sample into the unsigned magnitude used by both trackers.
// Positive mode passes the code through unchanged. Negative mode reads the
// code as two's complement and takes its absolute value. The most negative
// code maps to 2**(DATA_W-1), which still fits in DATA_W unsigned bits.
module sfd_magnitude #(
    parameter int DATA_W = 8
) (
    input  logic              neg_mode,
    input  logic [DATA_W-1:0] code,
    output logic [DATA_W-1:0] mag
);

    // Negate codes with the sign bit set when in negative mode.
    always_comb begin
        if (neg_mode && code[DATA_W-1]) begin
            mag = ~code + 1'b1;
        end else begin
            mag = code;
        end
    end

endmodule

// File: rtl/sfd_limit_track.sv
// Module: sfd_limit_track
// One side of the window: a set/release state with hysteresis on release.
// UPPER = 1 builds the high-side tracker: it trips above the threshold and
// releases below threshold minus hysteresis, floored at 0.
// UPPER = 0 builds the low-side tracker: it trips below the threshold and
// releases above threshold plus hysteresis, capped at all-ones.
// Assumes that the threshold and hysteresis are quasi-static; the state
// moves only on valid samples.
module sfd_limit_track #(
    parameter int DATA_W = 8,
    parameter int HYST_W = 5,
    parameter bit UPPER  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [DATA_W-1:0] mag,
    input  logic [DATA_W-1:0] thresh,
    input  logic [HYST_W-1:0] hyst,
    output logic              flag
);

    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0]  wide_lvl;
    logic [DATA_W-1:0] release_lvl;
    logic              trip;
    logic              release_ok;

    generate
        if (UPPER) begin : g_high
            // High side: the release level is the threshold minus hysteresis, floored at zero.
            always_comb begin
                wide_lvl    = {1'b0, thresh} - EXT_W'(hyst);
                release_lvl = wide_lvl[DATA_W] ? '0 : wide_lvl[DATA_W-1:0];
                trip        = (mag > thresh);
                release_ok  = (mag < release_lvl);
            end
        end else begin : g_low
            // Low side: the release level is the threshold plus hysteresis, capped at all-ones.
            always_comb begin
                wide_lvl    = {1'b0, thresh} + EXT_W'(hyst);
                release_lvl = wide_lvl[DATA_W] ? '1 : wide_lvl[DATA_W-1:0];
                trip        = (mag < thresh);
                release_ok  = (mag > release_lvl);
            end
        end
    endgenerate

    // State register: trip when clear, release when set, valid samples only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (valid) begin
            flag <= flag ? !release_ok : trip;
        end
    end

endmodule

// File: rtl/sfd_fault_select.sv
// Module: sfd_fault_select
// Picks the reported fault from the two tracker states using the selector.
// Purely combinational; the reserved code reports the window condition.
module sfd_fault_select
    import sfd_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       low_flag,
    input  logic       high_flag,
    output logic       fault
);

    fault_sel_e sel_e;

    // Decode the selector into the reported condition.
    always_comb begin
        sel_e = fault_sel_e'(sel);
        case (sel_e)
            SEL_HIGH: fault = high_flag;
            SEL_LOW:  fault = low_flag;
            default:  fault = low_flag | high_flag;
        endcase
    end

endmodule

// File: rtl/supply_window_fault.sv
// Module: supply_window_fault (top)
// Compares one supply sample stream against low and high limits, each with
// its own release hysteresis, and reports one raw fault flag.
// Assumes samples arrive with a one-cycle valid strobe and that the
// configuration inputs are held steady by the surrounding register file.
module supply_window_fault #(
    parameter int DATA_W = 8,
    parameter int HYST_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_code,
    input  logic              neg_mode,
    input  logic [DATA_W-1:0] uv_level,
    input  logic [DATA_W-1:0] ov_level,
    input  logic [HYST_W-1:0] uv_hyst,
    input  logic [HYST_W-1:0] ov_hyst,
    input  logic [1:0]        fault_sel,
    output logic              fault
);

    logic [DATA_W-1:0] mag_w;
    logic              uv_flag;
    logic              ov_flag;

    sfd_magnitude #(.DATA_W(DATA_W)) i_mag (
        .neg_mode (neg_mode),
        .code     (smp_code),
        .mag      (mag_w)
    );

    sfd_limit_track #(.DATA_W(DATA_W), .HYST_W(HYST_W), .UPPER(1'b0)) i_low (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (smp_valid),
        .mag    (mag_w),
        .thresh (uv_level),
        .hyst   (uv_hyst),
        .flag   (uv_flag)
    );

    sfd_limit_track #(.DATA_W(DATA_W), .HYST_W(HYST_W), .UPPER(1'b1)) i_high (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (smp_valid),
        .mag    (mag_w),
        .thresh (ov_level),
        .hyst   (ov_hyst),
        .flag   (ov_flag)
    );

    sfd_fault_select i_sel (
        .sel       (fault_sel),
        .low_flag  (uv_flag),
        .high_flag (ov_flag),
        .fault     (fault)
    );

endmodule

// File: rtl/sfd_checker.sv
// Module: sfd_checker
// Property checks for supply_window_fault, attached by bind below.
module sfd_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [DATA_W-1:0] mag,
    input logic [DATA_W-1:0] uv_level,
    input logic [DATA_W-1:0] ov_level,
    input logic              uv_flag,
    input logic              ov_flag,
    input logic [1:0]        fault_sel,
    input logic              fault
);

    assert_uv_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !uv_flag && (mag < uv_level)) |=> uv_flag);

    assert_uv_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && uv_flag && (mag <= uv_level)) |=> uv_flag);

    assert_ov_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !ov_flag && (mag > ov_level)) |=> ov_flag);

    assert_ov_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ov_flag && (mag >= ov_level)) |=> ov_flag);

    assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(uv_flag) && $stable(ov_flag)));

    assert_sel_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_sel == 2'b00) |-> (fault == ov_flag));

    assert_sel_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_sel == 2'b01) |-> (fault == uv_flag));

    assert_sel_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_sel[1] |-> (fault == (uv_flag || ov_flag)));

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (!uv_flag && !ov_flag));

endmodule

bind supply_window_fault sfd_checker i_sfd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .mag       (mag_w),
    .uv_level  (uv_level),
    .ov_level  (ov_level),
    .uv_flag   (uv_flag),
    .ov_flag   (ov_flag),
    .fault_sel (fault_sel),
    .fault     (fault)
);

// File: tb/test_supply_window_fault.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected flags, a monitor compares them.
module test_supply_window_fault;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_code = '0;
    logic       neg_mode = 1'b0;
    logic [7:0] uv_level = '0;
    logic [7:0] ov_level = 8'hFF;
    logic [4:0] uv_hyst = '0;
    logic [4:0] ov_hyst = '0;
    logic [1:0] fault_sel = 2'b10;
    logic       fault;

    always #2 clk = ~clk;

    supply_window_fault i_supply_window_fault (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .neg_mode(neg_mode), .uv_level(uv_level), .ov_level(ov_level),
        .uv_hyst(uv_hyst), .ov_hyst(ov_hyst), .fault_sel(fault_sel), .fault(fault)
    );

    typedef struct { logic exp; string req; } item_t;
    item_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit m_uv = 0;
    bit m_ov = 0;
    bit done = 0;

    function automatic logic model_out();
        case (fault_sel)
            2'b00:   return m_ov;
            2'b01:   return m_uv;
            default: return m_uv | m_ov;
        endcase
    endfunction

    task automatic push(input string req);
        item_t it;
        it.exp = model_out();
        it.req = req;
        q.push_back(it);
    endtask

    // Driver: one sample per call; the model follows the requirements.
    task automatic step(input bit v, input logic [7:0] code, input string req);
        int magi, uv_rel, ov_rel;
        @(negedge clk);
        smp_valid = v;
        smp_code  = code;
        @(posedge clk);
        if (v) begin
            magi   = (neg_mode && code[7]) ? 256 - int'(code) : int'(code);
            uv_rel = int'(uv_level) + int'(uv_hyst);
            if (uv_rel > 255) uv_rel = 255;
            ov_rel = int'(ov_level) - int'(ov_hyst);
            if (ov_rel < 0) ov_rel = 0;
            m_uv = m_uv ? !(magi > uv_rel) : (magi < int'(uv_level));
            m_ov = m_ov ? !(magi < ov_rel) : (magi > int'(ov_level));
        end
        push(req);
    endtask

    task automatic cfg(input logic [1:0] s, input logic n, input logic [7:0] u,
                       input logic [7:0] o, input logic [4:0] uh, input logic [4:0] oh);
        @(negedge clk);
        fault_sel = s; neg_mode = n; uv_level = u; ov_level = o;
        uv_hyst = uh; ov_hyst = oh; smp_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        @(posedge clk);
        m_uv = 0;
        m_ov = 0;
        push("R9");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compare one expected item shortly after each clock edge.
    always begin
        item_t it;
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            it = q.pop_front();
            n_chk++;
            if (fault !== it.exp) begin
                n_fail++;
                $display("FAIL %s: fault=%0b expected %0b", it.req, fault, it.exp);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        cfg(2'b10, 1'b0, 8'd100, 8'd200, 5'd5, 5'd5);
        do_reset();
        // R1 / R2: low-side trip and release boundary
        step(1, 8'd150, "R1");
        step(1, 8'd99,  "R1");
        step(1, 8'd103, "R2");
        step(1, 8'd105, "R2");
        step(1, 8'd106, "R2");
        // R3 / R4: high-side trip and release boundary
        step(1, 8'd201, "R3");
        step(1, 8'd196, "R4");
        step(1, 8'd195, "R4");
        step(1, 8'd194, "R4");
        // R6: an idle strobe ignores a sample far below the limit
        step(0, 8'd10,  "R6");
        step(1, 8'd10,  "R1");
        // R7: selector with only the low side tripped
        cfg(2'b00, 1'b0, 8'd100, 8'd200, 5'd5, 5'd5);
        step(0, 8'd10, "R7");
        cfg(2'b01, 1'b0, 8'd100, 8'd200, 5'd5, 5'd5);
        step(0, 8'd10, "R7");
        cfg(2'b11, 1'b0, 8'd100, 8'd200, 5'd5, 5'd5);
        step(0, 8'd10, "R7");
        // R5: full 5-bit hysteresis
        cfg(2'b01, 1'b0, 8'd100, 8'd200, 5'd31, 5'd5);
        step(1, 8'd131, "R5");
        step(1, 8'd132, "R5");
        // R10: saturated release levels
        cfg(2'b10, 1'b0, 8'd250, 8'd255, 5'd31, 5'd0);
        step(1, 8'd240, "R10");
        step(1, 8'd255, "R10");
        do_reset();
        cfg(2'b00, 1'b0, 8'd0, 8'd3, 5'd0, 5'd10);
        step(1, 8'd4, "R3");
        step(1, 8'd0, "R10");
        do_reset();
        // R8: negative rail compares magnitudes
        cfg(2'b10, 1'b1, 8'd40, 8'd100, 5'd0, 5'd0);
        step(1, 8'hCE, "R8");
        step(1, 8'hE2, "R8");
        step(1, 8'h88, "R8");
        cfg(2'b00, 1'b1, 8'd40, 8'd100, 5'd0, 5'd0);
        step(0, 8'h88, "R8");
        step(1, 8'h80, "R8");
        cfg(2'b10, 1'b1, 8'd40, 8'd100, 5'd0, 5'd0);
        step(1, 8'hC4, "R8");
        step(1, 8'h7F, "R8");
        @(posedge clk);
        @(posedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule